// File: doc/BRIEF.md
# Serial Management Bus Master with Missing-Target Recovery

This block is the master side of a two-wire management bus of the clause-22 kind. It drives a management clock and a shared data line. From a single request (direction, 5-bit device address, 5-bit register address and, for writes, a 16-bit value) it builds a whole read or write frame. When the frame ends it reports a 16-bit read result and a flag that says whether any target answered.

The clock is slowed down by a divisor taken from an input. Each low half and each high half of the management clock lasts `div_half + 1` system clock cycles. The divisor is captured when a request is accepted.

During a read the master listens to the second turnaround bit. If no target pulls that bit low, the master finishes with an all-ones result and the no-response flag set. Before it completes, it gives a stuck bus 32 extra clocks to recover.

The data line is modelled as three signals: an output value, an output enable and the level seen on the pin.

Top module: `mgmt_serial_master`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `mdc`, `md_oe`, `no_resp` and `rd_data` are all 0.
- R2: Every low and every high half of `mdc` lasts exactly `div_half+1` cycles. The value used is the one present when the request was accepted, and later changes to `div_half` have no effect on the running frame. The first low half begins in the cycle after acceptance.
- R3: Clock periods (bits) 0 to 31 of every frame drive the line high as a preamble. Bit 32 drives 0 and bit 33 drives 1.
- R4: Bits 34 and 35 carry the opcode, `10` for a read (`req_write`=0) and `01` for a write. Bits 36 to 40 carry `req_dev` and bits 41 to 45 carry `req_reg`, each field MSB first.
- R5: In a write, bits 46 and 47 drive 1 then 0. Bits 48 to 63 drive `req_wdata` MSB first. Bit 64 leaves the line released (`md_oe`=0), and the frame is 65 clock periods long.
- R6: In a read, `md_oe` is 0 from bit 46 onward. With a target present, the line is sampled at the rising `mdc` edge of bits 48 to 63, giving `rd_data` MSB first. One trailing clock (bit 64) follows, and the frame completes after 65 periods with `no_resp`=0.
- R7: If the line is high at the rising edge of bit 47 in a read, the frame runs 32 further clock periods (80 in total). It then completes with `rd_data`=16'hFFFF and `no_resp`=1.
- R8: `md_out` and `md_oe` change only at the edge where `mdc` falls or while it is low. They are steady across every high half.
- R9: `busy` rises in the cycle after a request is accepted and stays high until `done`. `done` is a one-cycle pulse in the cycle `busy` returns to 0. Requests presented while busy are ignored. While idle, `mdc` and `md_oe` are 0.
- R10: `rd_data` and `no_resp` change only at `done`. A completed write leaves `rd_data` unchanged and clears `no_resp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_half | input | DIV_W | Half-period of `mdc` minus one, in system cycles |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_dev | input | 5 | Target device address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Result of the last read |
| no_resp | output | 1 | Last read found no target |
| mdc | output | 1 | Management clock |
| md_out | output | 1 | Value driven onto the data line |
| md_oe | output | 1 | Data line driver enable |
| md_in | input | 1 | Level seen on the data line |

## Verification
The bench keeps the default `DIV_W` of 8 and drives `div_half` at 0, 1, 2 and 3 at run time. With 0 the clock runs at its fastest, one cycle per half. The larger values expose off-by-one errors in the half-period count. During one slow frame the divisor is moved to 0 while a competing request is held high, which tests both the captured divisor and the busy-time rejection. A target model in the bench answers by counting rising `mdc` edges, or stays silent so that the recovery path and its 80-period frame are reached.

// File: rtl/mgmt_pkg.sv
// Shared frame geometry, opcodes and phase encoding for the management bus master.
// Assumes clause-22 framing: preamble, start, opcode, two 5-bit addresses,
// two turnaround bits, 16 data bits.
package mgmt_pkg;
    localparam int PRE_LEN    = 32;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int RECOV_LEN  = 32;
    localparam int TRAIL_LEN  = 1;

    localparam int HDR_LEN     = PRE_LEN + 4 + 2 * ADDR_W;       // bits driven by both frame kinds
    localparam int TA_LAST     = HDR_LEN + 1;                     // second turnaround bit
    localparam int DATA_FIRST  = HDR_LEN + 2;
    localparam int DATA_LAST   = DATA_FIRST + DATA_W - 1;
    localparam int FRAME_LAST  = DATA_LAST + TRAIL_LEN;
    localparam int ABSENT_LAST = TA_LAST + RECOV_LEN;
    localparam int SHIFT_W     = HDR_LEN + 2 + DATA_W;
    localparam int BIT_W       = $clog2(ABSENT_LAST + 1);

    localparam logic [1:0] START_BITS = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] TA_DRIVE   = 2'b10;

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;
endpackage

// File: rtl/mgmt_tick_gen.sv
// Half-period timer: pulses tick once every half_len+1 cycles while run is high.
// Assumes half_len is held steady by the caller for the whole frame.
module mgmt_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half_len);

    // Count cycles inside the current half period, restarting on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mgmt_tx_shift.sv
// Outgoing frame register: loaded whole at acceptance, shifted out MSB first.
// Assumes shift is asserted once per bit, at the end of the bit.
module mgmt_tx_shift #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] q;

    assign msb = q[W-1];

    // Hold, load or advance the outgoing bit stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mgmt_rx_capture.sv
// Incoming data register: appends one sampled bit per capture strobe, MSB first.
// Assumes the caller strobes exactly W times per read.
module mgmt_rx_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         din,
    output logic [W-1:0] word
);
    // Shift in the sampled line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (cap) begin
            word <= {word[W-2:0], din};
        end
    end
endmodule

// File: rtl/mgmt_frame_ctrl.sv
// Frame sequencer: walks the bit index through low and high halves of the
// management clock. It decides driver enable, sampling, turnaround checking,
// recovery length and completion.
// Assumes tick comes from a timer that runs only while busy.
module mgmt_frame_ctrl
    import mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              tick,
    input  logic              md_in,
    input  logic [DATA_W-1:0] rx_word,
    output logic [DIV_W-1:0]  div_q,
    output logic              load,
    output logic              shift,
    output logic              cap,
    output logic              busy,
    output logic              done,
    output logic              mdc,
    output logic              md_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_resp
);
    localparam logic [BIT_W-1:0] TA_IDX     = BIT_W'(TA_LAST);
    localparam logic [BIT_W-1:0] DFIRST_IDX = BIT_W'(DATA_FIRST);
    localparam logic [BIT_W-1:0] DLAST_IDX  = BIT_W'(DATA_LAST);
    localparam logic [BIT_W-1:0] FLAST_IDX  = BIT_W'(FRAME_LAST);
    localparam logic [BIT_W-1:0] ALAST_IDX  = BIT_W'(ABSENT_LAST);
    localparam logic [BIT_W-1:0] HDR_IDX    = BIT_W'(HDR_LEN);

    phase_t           phase;
    logic [BIT_W-1:0] bitcnt;
    logic             is_wr;
    logic             absent;
    logic [BIT_W-1:0] last_idx;
    logic [BIT_W-1:0] drive_end;

    assign busy      = (phase != PH_IDLE);
    assign mdc       = (phase == PH_HIGH);
    assign load      = (phase == PH_IDLE) && req_valid;
    assign shift     = (phase == PH_HIGH) && tick;
    assign last_idx  = (!is_wr && absent) ? ALAST_IDX : FLAST_IDX;
    assign drive_end = is_wr ? FLAST_IDX : HDR_IDX;
    assign md_oe     = busy && (bitcnt < drive_end);

    // Strobe data capture at the rising clock edge of each read data bit.
    always_comb begin
        cap = 1'b0;
        if ((phase == PH_LOW) && tick && !is_wr &&
            (bitcnt >= DFIRST_IDX) && (bitcnt <= DLAST_IDX)) begin
            cap = 1'b1;
        end
    end

    // Sequence phases and bits, detect a silent target and post results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bitcnt  <= '0;
            is_wr   <= 1'b0;
            absent  <= 1'b0;
            div_q   <= '0;
            done    <= 1'b0;
            rd_data <= '0;
            no_resp <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase  <= PH_LOW;
                        bitcnt <= '0;
                        is_wr  <= req_write;
                        absent <= 1'b0;
                        div_q  <= div_in;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        phase <= PH_HIGH;
                        if (!is_wr && (bitcnt == TA_IDX) && md_in) begin
                            absent <= 1'b1;
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (bitcnt == last_idx) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            if (is_wr) begin
                                no_resp <= 1'b0;
                            end else begin
                                rd_data <= absent ? '1 : rx_word;
                                no_resp <= absent;
                            end
                        end else begin
                            phase  <= PH_LOW;
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mgmt_serial_master.sv
// Top of the management bus master: assembles the outgoing frame word and
// joins timer, shift registers and sequencer.
// Assumes md_in reflects the pin, including the master's own drive.
module mgmt_serial_master
    import mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_half,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_dev,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_resp,
    output logic              mdc,
    output logic              md_out,
    output logic              md_oe,
    input  logic              md_in
);
    logic [SHIFT_W-1:0] frame_word;
    logic [DIV_W-1:0]   div_q;
    logic               tick, load, shift, cap, tx_msb;
    logic [DATA_W-1:0]  rx_word;

    assign frame_word = {{PRE_LEN{1'b1}}, START_BITS,
                         (req_write ? OP_WRITE : OP_READ),
                         req_dev, req_reg, TA_DRIVE, req_wdata};
    assign md_out = tx_msb & md_oe;

    mgmt_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .half_len(div_q), .tick(tick)
    );

    mgmt_tx_shift #(.W(SHIFT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(frame_word),
        .shift(shift), .msb(tx_msb)
    );

    mgmt_rx_capture #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cap(cap), .din(md_in), .word(rx_word)
    );

    mgmt_frame_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .div_in(div_half), .tick(tick), .md_in(md_in), .rx_word(rx_word),
        .div_q(div_q), .load(load), .shift(shift), .cap(cap), .busy(busy),
        .done(done), .mdc(mdc), .md_oe(md_oe), .rd_data(rd_data), .no_resp(no_resp)
    );
endmodule

// File: rtl/mgmt_serial_master_chk.sv
// Property checker for the management bus master, attached by bind.
module mgmt_serial_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mdc,
    input logic              md_oe,
    input logic              md_out,
    input logic [DATA_W-1:0] rd_data,
    input logic              no_resp
);
    // R1
    after_reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mdc && !md_oe && !no_resp));

    // R2
    clock_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

    // R8
    line_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(md_oe) && $stable(md_out)));

    // R9
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !md_oe));

    // R7
    absent_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_resp) |-> (rd_data == {DATA_W{1'b1}}));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rd_data) && $stable(no_resp)));
endmodule

bind mgmt_serial_master mgmt_serial_master_chk #(.DATA_W(mgmt_pkg::DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mdc(mdc),
    .md_oe(md_oe), .md_out(md_out), .rd_data(rd_data), .no_resp(no_resp)
);

// File: tb/mgmt_serial_master_bench.sv
module mgmt_serial_master_bench;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_half = '0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [4:0]       req_dev = '0;
    logic [4:0]       req_reg = '0;
    logic [15:0]      req_wdata = '0;
    logic             busy, done, no_resp, mdc, md_out, md_oe, md_in;
    logic [15:0]      rd_data;

    // target model state
    int          r = 0;
    bit          tgt_present = 1'b0;
    bit          tgt_rd = 1'b0;
    logic [15:0] tgt_word = '0;
    logic        tgt_drv, tgt_val;

    int n_checks = 0;
    int n_err = 0;

    // reference model state
    int          q[$];
    bit          cur_wr, cur_abs, pend_done, popped;
    logic [15:0] m_rd = '0, pend_rd = '0;
    bit          m_nr = 1'b0, pend_nr = 1'b0;
    string       pend_tag = "R10";

    always #4 clk = ~clk;

    mgmt_serial_master #(.DIV_W(DIV_W)) u_mgmt_serial_master (
        .clk(clk), .rst_n(rst_n), .div_half(div_half), .req_valid(req_valid),
        .req_write(req_write), .req_dev(req_dev), .req_reg(req_reg),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .no_resp(no_resp), .mdc(mdc), .md_out(md_out), .md_oe(md_oe), .md_in(md_in)
    );

    assign tgt_drv = tgt_present && tgt_rd && (r >= 47) && (r <= 63);
    assign tgt_val = (r >= 48 && r <= 63) ? tgt_word[63 - r] : 1'b0;
    assign md_in   = md_oe ? md_out : (tgt_drv ? tgt_val : 1'b1);

    always @(posedge mdc) r = r + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int b, input bit wr, input logic [4:0] dv,
                                   input logic [4:0] rg, input logic [15:0] wd);
        if (b < 32) return 1'b1;
        if (b == 32) return 1'b0;
        if (b == 33) return 1'b1;
        if (b == 34) return !wr;
        if (b == 35) return wr;
        if (b <= 40) return dv[40 - b];
        if (b <= 45) return rg[45 - b];
        if (b == 46) return 1'b1;
        if (b == 47) return 1'b0;
        if (b <= 63) return wd[63 - b];
        return 1'b0;
    endfunction

    function automatic string region_tag(input int b);
        if (b < 34) return "R3";
        if (b < 46) return "R4";
        if (cur_wr) return "R5";
        if (cur_abs && b >= 48) return "R7";
        return "R6";
    endfunction

    // Build the expected per-cycle stream of (bit, mdc, oe, out) for a new frame.
    task automatic build_frame();
        int nbits, d, lim;
        cur_wr  = req_write;
        cur_abs = !req_write && !tgt_present;
        nbits   = cur_abs ? 80 : 65;
        d       = int'(div_half);
        lim     = cur_wr ? 64 : 46;
        for (int b = 0; b < nbits; b++) begin
            bit oe = (b < lim);
            bit o  = oe ? exp_bit(b, cur_wr, req_dev, req_reg, req_wdata) : 1'b0;
            for (int h = 0; h < 2; h++) begin
                for (int k = 0; k <= d; k++) begin
                    q.push_back((b << 3) | (h << 2) | (int'(oe) << 1) | int'(o));
                end
            end
        end
        if (cur_wr) begin
            pend_rd = m_rd; pend_nr = 1'b0; pend_tag = "R10";
        end else if (cur_abs) begin
            pend_rd = 16'hFFFF; pend_nr = 1'b1; pend_tag = "R7";
        end else begin
            pend_rd = tgt_word; pend_nr = 1'b0; pend_tag = "R6";
        end
    endtask

    // Compare the design with the model once per cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            string rtag;
            popped = 1'b0;
            rtag = "R10";
            if (pend_done) begin
                chk(done === 1'b1, "R9", "done pulse", int'(done), 1);
                chk(busy === 1'b0, "R9", "busy at done", int'(busy), 0);
                m_rd = pend_rd; m_nr = pend_nr; rtag = pend_tag;
                pend_done = 1'b0;
            end else begin
                chk(done === 1'b0, "R9", "done idle", int'(done), 0);
            end
            if (q.size() > 0) begin
                int e, b;
                e = q.pop_front();
                b = e >> 3;
                chk(mdc === e[2], "R2", $sformatf("mdc bit %0d", b), int'(mdc), e[2]);
                chk(md_oe === e[1], region_tag(b), $sformatf("md_oe bit %0d", b), int'(md_oe), e[1]);
                if (e[1]) begin
                    chk(md_out === e[0], region_tag(b), $sformatf("md_out bit %0d", b), int'(md_out), e[0]);
                end
                chk(busy === 1'b1, "R9", "busy in frame", int'(busy), 1);
                popped = 1'b1;
                if (q.size() == 0) pend_done = 1'b1;
            end else begin
                chk(busy === 1'b0 && mdc === 1'b0 && md_oe === 1'b0, "R9", "idle outputs",
                    int'({busy, mdc, md_oe}), 0);
            end
            chk(rd_data === m_rd, rtag, "rd_data", int'(rd_data), int'(m_rd));
            chk(no_resp === m_nr, rtag, "no_resp", int'(no_resp), int'(m_nr));
            if (req_valid && !popped && q.size() == 0) build_frame();
        end
    end

    task automatic do_req(input bit wr, input logic [4:0] dv, input logic [4:0] rg,
                          input logic [15:0] wd, input bit present,
                          input logic [15:0] word, input int d, input bit poke);
        @(posedge clk); #1;
        r = 0;
        tgt_present = present; tgt_rd = !wr; tgt_word = word;
        div_half = DIV_W'(d);
        req_write = wr; req_dev = dv; req_reg = rg; req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (poke) begin
            // R9 request ignored while busy, R2 divisor change ignored mid-frame
            repeat (20) @(posedge clk);
            #1;
            req_valid = 1'b1; req_write = ~wr; req_dev = ~dv; req_reg = ~rg;
            req_wdata = ~wd; div_half = '0;
            repeat (5) @(posedge clk);
            #1;
            req_valid = 1'b0;
        end
        while (q.size() != 0 || pend_done) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1", "busy", int'(busy), 0);
        chk(done === 1'b0, "R1", "done", int'(done), 0);
        chk(mdc === 1'b0, "R1", "mdc", int'(mdc), 0);
        chk(md_oe === 1'b0, "R1", "md_oe", int'(md_oe), 0);
        chk(rd_data === 16'h0, "R1", "rd_data", int'(rd_data), 0);
        chk(no_resp === 1'b0, "R1", "no_resp", int'(no_resp), 0);
        // R5 write at the fastest clock
        do_req(1'b1, 5'h11, 5'h0A, 16'hA5C3, 1'b1, 16'h0, 0, 1'b0);
        // R6 read with target present
        do_req(1'b0, 5'h1F, 5'h00, 16'h0, 1'b1, 16'h3C96, 0, 1'b0);
        // R7 read with no target, slower clock
        do_req(1'b0, 5'h02, 5'h15, 16'h0, 1'b0, 16'h0, 2, 1'b0);
        // R10 write after an absent read keeps rd_data and clears no_resp
        do_req(1'b1, 5'h00, 5'h1F, 16'hFFFF, 1'b1, 16'h0, 1, 1'b0);
        // R2 and R9 mid-frame divisor change and competing request
        do_req(1'b0, 5'h0B, 5'h07, 16'h0, 1'b1, 16'h8001, 3, 1'b1);
        // R6 back-to-back read straight after completion
        do_req(1'b0, 5'h15, 5'h1A, 16'h0, 1'b1, 16'h7E5A, 0, 1'b0);
        // R4 write with alternating address bits
        do_req(1'b1, 5'h0A, 5'h15, 16'h0001, 1'b1, 16'h0, 1, 1'b0);
        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule